// File: doc/BRIEF.md
# Stack-Window Operand Cache

This block keeps the words that sit just above the stack pointer in a small, fast store. An instruction names one of these words with a 5-bit offset, much as it would name a register. Two offset operands can be read in the same cycle and one can be written. A load or store that carries a full word address is served from the same store when its address lies inside the window. Pointer aliases of stack variables therefore see the same data as offset accesses. Full-address accesses that fall outside the window are passed to memory unchanged.

There are no address tags. A word hits when it is valid and its address lies in the contiguous range that starts at the stack pointer and spans DEPTH words. Data sits at index address modulo DEPTH, so moving the pointer never shifts stored words. Misses never allocate. The window grows only through an allocate command, which lowers the pointer at procedure entry, and shrinks only through a deallocate command, which raises it at procedure exit. An allocate writes dirty words back to memory as they drop off the far end of the window. A deallocate reads in the words that newly enter the window. Reloading the pointer directly, as an interrupt would, discards the old contents without saving them.

Top module: `tos_window`

## Requirements
- R1: After reset the pointer equals SP_RESET, `ready` is high, and every offset reads with its valid flag low.
- R2: Each read port returns, in the same cycle and without a clock edge, the stored word at address `sp + offset` together with that entry's valid flag. The offset is 5 bits wide and the two ports work independently.
- R3: A stack-relative write stores the word at `sp + wr_off` and marks it valid and dirty. While `ready` is high, a write is forwarded in the same cycle to any read port that has the same offset.
- R4: A full-address access hits when `(fa_addr - sp) mod 2^AW < DEPTH` and the entry is valid, including when the window wraps past the top of the address space. A hit sets `fa_hit` and `fa_ack` in the same cycle and issues no memory request. A hit write changes the word seen at the matching offset.
- R5: A full-address miss, including an in-range word whose entry is invalid, drives `mem_req` with the same address, direction and data. `fa_ack` and `fa_rdata` follow `mem_ack` and `mem_rdata`, and the window contents do not change.
- R6: An allocate of n words lowers the pointer by n and holds `ready` low until it is done. Each dirty word that leaves the window is written to its own address (`mem_we`=1). A clean word that leaves causes no memory traffic. Each newly covered word reads as valid.
- R7: A deallocate of n words raises the pointer by n. Each word that newly enters the window is read from memory (`mem_we`=0) and becomes valid before `ready` returns high. Words that leave are dropped without a write.
- R8: An allocate or deallocate with n = 0 leaves the pointer, the contents and memory unchanged, and `ready` stays high.
- R9: A pointer load sets `sp` to `ld_sp` and marks every entry invalid and clean. It causes no memory traffic, so addresses in the old window miss afterwards.
- R10: Words keep their values across pointer moves. After an allocate of n, offset k+n returns what offset k returned before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load the pointer directly (taken when ready) |
| ld_sp | input | AW | New pointer value |
| cmd_alloc | input | 1 | Allocate command (procedure entry) |
| cmd_dealloc | input | 1 | Deallocate command (procedure exit) |
| cmd_n | input | OW+1 | Number of words to move the pointer by |
| ready | output | 1 | Idle; commands and accesses are accepted |
| sp | output | AW | Current stack pointer (word address) |
| ra_off | input | OW | Read port A offset |
| ra_data | output | DW | Read port A data |
| ra_valid | output | 1 | Read port A entry valid |
| rb_off | input | OW | Read port B offset |
| rb_data | output | DW | Read port B data |
| rb_valid | output | 1 | Read port B entry valid |
| wr_en | input | 1 | Stack-relative write enable |
| wr_off | input | OW | Write offset |
| wr_data | input | DW | Write data |
| fa_req | input | 1 | Full-address access request, held until fa_ack |
| fa_we | input | 1 | Full-address access is a store |
| fa_addr | input | AW | Full word address |
| fa_wdata | input | DW | Store data |
| fa_rdata | output | DW | Load data |
| fa_ack | output | 1 | Access complete this cycle |
| fa_hit | output | 1 | Access served from the window |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory request complete |

## Verification
Both read ports are swept over all 32 offsets in opposite orders after each pointer move. This separates a correct modulo index from one that is off by one or that mixes up the ports. The allocates are run in two cases: one where every leaving word is clean, with no traffic expected, and one where every leaving word is dirty, with write-backs expected at exact addresses. The deallocates are run twice: once filling from words just written back, and once filling from untouched memory. Full-address probes at sp-1, sp, sp+31 and sp+32, at an in-range but invalid word, and in a window that wraps around the top of memory, pin down the bounds comparison and the valid qualifier.

// File: rtl/tos_window.sv
`timescale 1ns/1ps
module tos_window #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int DEPTH = 32,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [AW-1:0]            ld_sp,
  input  logic                     cmd_alloc,
  input  logic                     cmd_dealloc,
  input  logic [$clog2(DEPTH):0]   cmd_n,
  output logic                     ready,
  output logic [AW-1:0]            sp,
  input  logic [$clog2(DEPTH)-1:0] ra_off,
  output logic [DW-1:0]            ra_data,
  output logic                     ra_valid,
  input  logic [$clog2(DEPTH)-1:0] rb_off,
  output logic [DW-1:0]            rb_data,
  output logic                     rb_valid,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_off,
  input  logic [DW-1:0]            wr_data,
  input  logic                     fa_req,
  input  logic                     fa_we,
  input  logic [AW-1:0]            fa_addr,
  input  logic [DW-1:0]            fa_wdata,
  output logic [DW-1:0]            fa_rdata,
  output logic                     fa_ack,
  output logic                     fa_hit,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     mem_ack
);
  localparam int OW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_SPILL, S_FILL} st_t;
  st_t st;

  logic [DW-1:0]    word_q [DEPTH];
  logic [DEPTH-1:0] vld_q, dty_q;
  logic [OW:0]      left_q;

  logic [OW-1:0] base, ia, ib, iw, ifa, istep;
  logic [AW-1:0] fa_dist, step_addr;
  logic          wr_go, fwd_a, fwd_b, fa_wr_hit, step_go;

  assign base    = sp[OW-1:0];
  assign ia      = base + ra_off;
  assign ib      = base + rb_off;
  assign iw      = base + wr_off;
  assign ifa     = fa_addr[OW-1:0];
  assign istep   = (st == S_SPILL) ? base - OW'(1) : base;
  assign fa_dist = fa_addr - sp;
  assign step_addr = sp + AW'(DEPTH) - ((st == S_SPILL) ? AW'(1) : AW'(0));

  assign ready  = (st == S_IDLE);
  assign wr_go  = ready & wr_en;
  assign fwd_a  = wr_go && (wr_off == ra_off);
  assign fwd_b  = wr_go && (wr_off == rb_off);

  assign ra_valid = fwd_a | vld_q[ia];
  assign ra_data  = fwd_a ? wr_data : word_q[ia];
  assign rb_valid = fwd_b | vld_q[ib];
  assign rb_data  = fwd_b ? wr_data : word_q[ib];

  assign fa_hit    = (fa_dist < AW'(DEPTH)) && vld_q[ifa];
  assign fa_ack    = ready & fa_req & (fa_hit | mem_ack);
  assign fa_rdata  = fa_hit ? word_q[ifa] : mem_rdata;
  assign fa_wr_hit = ready & fa_req & fa_we & fa_hit;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = step_addr;
    mem_wdata = word_q[istep];
    case (st)
      S_IDLE: begin
        mem_req   = fa_req & ~fa_hit;
        mem_we    = fa_we;
        mem_addr  = fa_addr;
        mem_wdata = fa_wdata;
      end
      S_SPILL: begin
        mem_req = dty_q[istep];
        mem_we  = 1'b1;
      end
      default: mem_req = 1'b1;
    endcase
  end

  assign step_go = ((st == S_SPILL) && (!dty_q[istep] || mem_ack)) ||
                   ((st == S_FILL) && mem_ack);

  always_ff @(posedge clk) begin
    if (fa_wr_hit) word_q[ifa] <= fa_wdata;
    if (wr_go) word_q[iw] <= wr_data;
    if (st == S_FILL && mem_ack) word_q[istep] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sp     <= SP_RESET;
      vld_q  <= '0;
      dty_q  <= '0;
      left_q <= '0;
    end else if (st == S_IDLE) begin
      if (fa_wr_hit) dty_q[ifa] <= 1'b1;
      if (wr_go) begin
        vld_q[iw] <= 1'b1;
        dty_q[iw] <= 1'b1;
      end
      if (ld_en) begin
        sp    <= ld_sp;
        vld_q <= '0;
        dty_q <= '0;
      end else if (cmd_alloc && cmd_n != '0) begin
        st     <= S_SPILL;
        left_q <= cmd_n;
      end else if (cmd_dealloc && cmd_n != '0) begin
        st     <= S_FILL;
        left_q <= cmd_n;
      end
    end else if (step_go) begin
      vld_q[istep] <= 1'b1;
      dty_q[istep] <= 1'b0;
      sp     <= (st == S_SPILL) ? sp - AW'(1) : sp + AW'(1);
      left_q <= left_q - 1'b1;
      if (left_q == (OW+1)'(1)) st <= S_IDLE;
    end
  end

  p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && fa_req && fa_hit) |-> (!mem_req && fa_ack));

  p_miss_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && fa_req && !fa_hit) |-> (mem_req && mem_addr == fa_addr && fa_ack == mem_ack));

  p_spill_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPILL && mem_req) |-> (mem_we && !ready));

  p_fill_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) |-> (mem_req && !mem_we && !ready));

  p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ld_en && !((cmd_alloc || cmd_dealloc) && cmd_n != '0)) |=> $stable(sp));

  p_load_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ld_en) |=> (sp == $past(ld_sp) && (!ra_valid || wr_en) && (!rb_valid || wr_en)));
endmodule

// File: tb/tb_tos_window.sv
`timescale 1ns/1ps
module tb_tos_window;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ld_en = 0, cmd_alloc = 0, cmd_dealloc = 0, wr_en = 0, fa_req = 0, fa_we = 0, mem_ack = 0;
  logic [AW-1:0] ld_sp = '0, fa_addr = '0;
  logic [5:0] cmd_n = '0;
  logic [4:0] ra_off = '0, rb_off = '0, wr_off = '0;
  logic [DW-1:0] wr_data = '0, fa_wdata = '0, mem_rdata = '0;
  logic ready, ra_valid, rb_valid, fa_ack, fa_hit, mem_req, mem_we;
  logic [AW-1:0] sp, mem_addr;
  logic [DW-1:0] ra_data, rb_data, fa_rdata, mem_wdata;

  tos_window #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .SP_RESET(8'h80)) dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sp(ld_sp),
    .cmd_alloc(cmd_alloc), .cmd_dealloc(cmd_dealloc), .cmd_n(cmd_n),
    .ready(ready), .sp(sp),
    .ra_off(ra_off), .ra_data(ra_data), .ra_valid(ra_valid),
    .rb_off(rb_off), .rb_data(rb_data), .rb_valid(rb_valid),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .fa_req(fa_req), .fa_we(fa_we), .fa_addr(fa_addr), .fa_wdata(fa_wdata),
    .fa_rdata(fa_rdata), .fa_ack(fa_ack), .fa_hit(fa_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  logic [DW-1:0] bm [256];
  logic [DW-1:0] ex [256];
  bit ev [256];
  bit kn [256];
  bit dt [256];
  logic [AW-1:0] sp_m;
  int n_chk = 0, n_fail = 0, mw_cnt = 0, mr_cnt = 0, lat = 0;

  initial for (int i = 0; i < 256; i++) begin
    bm[i] = 32'hB000_0000 | i;
    ex[i] = '0; ev[i] = 0; kn[i] = 0; dt[i] = 0;
  end

  always @(posedge clk) begin
    #1;
    if (mem_ack) begin
      mem_ack = 0;
      lat = 0;
    end else if (mem_req) begin
      if (lat == 1) begin
        mem_ack = 1;
        lat = 0;
        if (mem_we) begin bm[mem_addr] = mem_wdata; mw_cnt++; end
        else begin mem_rdata = bm[mem_addr]; mr_cnt++; end
      end else lat++;
    end else lat = 0;
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] val(input int k);
    return 32'h5A00_0000 + k * 32'h0001_0003;
  endfunction

  task automatic sweep(input string req);
    for (int k = 0; k < DEPTH; k++) begin
      logic [AW-1:0] a, b;
      @(negedge clk);
      ra_off = 5'(k); rb_off = 5'(DEPTH - 1 - k);
      #1;
      a = sp_m + AW'(k); b = sp_m + AW'(DEPTH - 1 - k);
      chk(ra_valid == ev[a], req, 32'(ra_valid), 32'(ev[a]));
      chk(rb_valid == ev[b], req, 32'(rb_valid), 32'(ev[b]));
      if (ev[a] && kn[a]) chk(ra_data == ex[a], req, ra_data, ex[a]);
      if (ev[b] && kn[b]) chk(rb_data == ex[b], req, rb_data, ex[b]);
    end
    chk(sp == sp_m, req, 32'(sp), 32'(sp_m));
  endtask

  task automatic wait_ready;
    while (!ready) @(negedge clk);
  endtask

  task automatic do_cmd(input bit al, input int n, input string req);
    @(negedge clk);
    cmd_alloc = al; cmd_dealloc = !al; cmd_n = 6'(n);
    @(negedge clk);
    cmd_alloc = 0; cmd_dealloc = 0;
    if (n != 0) chk(ready == 1'b0, req, 32'(ready), 32'd0);
    wait_ready();
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      if (al) begin
        a = sp_m - AW'(1 + i);
        ev[a + AW'(DEPTH)] = 0; dt[a + AW'(DEPTH)] = 0;
        ev[a] = 1; kn[a] = 0; dt[a] = 0;
      end else begin
        a = sp_m + AW'(i);
        ev[a] = 0; dt[a] = 0;
        ev[a + AW'(DEPTH)] = 1; kn[a + AW'(DEPTH)] = 1; dt[a + AW'(DEPTH)] = 0;
        ex[a + AW'(DEPTH)] = bm[a + AW'(DEPTH)];
      end
    end
    sp_m = al ? sp_m - AW'(n) : sp_m + AW'(n);
  endtask

  task automatic swr(input int off, input logic [DW-1:0] d);
    logic [AW-1:0] a;
    @(negedge clk);
    wr_en = 1; wr_off = 5'(off); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    a = sp_m + AW'(off);
    ex[a] = d; ev[a] = 1; kn[a] = 1; dt[a] = 1;
  endtask

  task automatic fa(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] d, input string req);
    bit exp_hit;
    logic [DW-1:0] exp_d, got;
    int mw0, mr0;
    exp_hit = (8'(addr - sp_m) < 8'(DEPTH)) && ev[addr];
    exp_d = exp_hit ? ex[addr] : bm[addr];
    mw0 = mw_cnt; mr0 = mr_cnt;
    @(negedge clk);
    fa_req = 1; fa_we = we; fa_addr = addr; fa_wdata = d;
    #1;
    chk(fa_hit == exp_hit, req, 32'(fa_hit), 32'(exp_hit));
    while (!fa_ack) begin @(posedge clk); #2; end
    got = fa_rdata;
    @(negedge clk);
    fa_req = 0; fa_we = 0;
    if (!we) chk(got == exp_d, req, got, exp_d);
    if (exp_hit) begin
      chk(mw_cnt == mw0 && mr_cnt == mr0, req, 32'(mw_cnt + mr_cnt), 32'(mw0 + mr0));
      if (we) begin ex[addr] = d; dt[addr] = 1; end
    end else if (we) begin
      chk(bm[addr] == d, req, bm[addr], d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int mw0, mr0;
    sp_m = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1", 32'(ready), 32'd1);
    chk(sp == 8'h80, "R1", 32'(sp), 32'h80);
    sweep("R1");

    // R6 allocate over clean words: no traffic
    do_cmd(1, 32, "R6");
    chk(mw_cnt == 0 && mr_cnt == 0, "R6", 32'(mw_cnt + mr_cnt), 32'd0);
    sweep("R6");

    // R2/R3 write all offsets then dual-port sweep
    for (int k = 0; k < DEPTH; k++) swr(k, val(k));
    sweep("R2");

    // R3 same-cycle forwarding to both ports
    @(negedge clk);
    wr_en = 1; wr_off = 5'd5; wr_data = 32'hFEED_0005; ra_off = 5'd5; rb_off = 5'd5;
    #1;
    chk(ra_data == 32'hFEED_0005 && ra_valid, "R3", ra_data, 32'hFEED_0005);
    chk(rb_data == 32'hFEED_0005 && rb_valid, "R3", rb_data, 32'hFEED_0005);
    @(negedge clk);
    wr_en = 0;
    ex[sp_m + 8'd5] = 32'hFEED_0005; dt[sp_m + 8'd5] = 1;
    #1;
    chk(ra_data == 32'hFEED_0005, "R3", ra_data, 32'hFEED_0005);

    // R6/R10 allocate 4 over dirty words: exact write-backs, data does not shift
    mw0 = mw_cnt;
    do_cmd(1, 4, "R6");
    chk(mw_cnt == mw0 + 4, "R6", 32'(mw_cnt), 32'(mw0 + 4));
    for (int i = 28; i < 32; i++)
      chk(bm[8'h60 + 8'(i)] == val(i), "R6", bm[8'h60 + 8'(i)], val(i));
    @(negedge clk); ra_off = 5'd9; #1;
    chk(ra_data == 32'hFEED_0005, "R10", ra_data, 32'hFEED_0005);
    sweep("R10");

    // R7 deallocate 4: fills words just written back
    mr0 = mr_cnt; mw0 = mw_cnt;
    do_cmd(0, 4, "R7");
    chk(mr_cnt == mr0 + 4 && mw_cnt == mw0, "R7", 32'(mr_cnt), 32'(mr0 + 4));
    sweep("R7");

    // R7 deallocate 3: fill from untouched memory, dirty leaving words dropped
    mr0 = mr_cnt; mw0 = mw_cnt;
    do_cmd(0, 3, "R7");
    chk(mw_cnt == mw0, "R7", 32'(mw_cnt), 32'(mw0));
    chk(mr_cnt == mr0 + 3, "R7", 32'(mr_cnt), 32'(mr0 + 3));
    for (int i = 0; i < 3; i++)
      chk(bm[8'h60 + 8'(i)] == (32'hB000_0000 | (8'h60 + i)), "R7", bm[8'h60 + 8'(i)], 32'hB000_0000 | (8'h60 + i));
    sweep("R7");

    // R8 zero-size commands
    mr0 = mr_cnt; mw0 = mw_cnt;
    do_cmd(1, 0, "R8");
    chk(ready == 1'b1, "R8", 32'(ready), 32'd1);
    do_cmd(0, 0, "R8");
    chk(mw_cnt == mw0 && mr_cnt == mr0, "R8", 32'(mw_cnt + mr_cnt), 32'(mw0 + mr0));
    sweep("R8");

    // R4 hits: inside, alias write, top boundary
    fa(0, sp_m + 8'd7, '0, "R4");
    fa(1, sp_m + 8'd9, 32'hA11A_5009, "R4");
    fa(0, sp_m + 8'd31, '0, "R4");
    fa(0, sp_m, '0, "R4");
    sweep("R4");

    // R5 misses: just below and just above the window, write miss
    fa(0, sp_m - 8'd1, '0, "R5");
    fa(0, sp_m + 8'd32, '0, "R5");
    fa(1, 8'h10, 32'h0DD0_0010, "R5");
    sweep("R5");

    // R9 pointer load drops contents without traffic
    mr0 = mr_cnt; mw0 = mw_cnt;
    @(negedge clk); ld_en = 1; ld_sp = 8'h20;
    @(negedge clk); ld_en = 0;
    for (int i = 0; i < 256; i++) begin ev[i] = 0; dt[i] = 0; end
    sp_m = 8'h20;
    chk(sp == 8'h20, "R9", 32'(sp), 32'h20);
    chk(mw_cnt == mw0 && mr_cnt == mr0, "R9", 32'(mw_cnt + mr_cnt), 32'(mw0 + mr0));
    sweep("R9");
    fa(0, 8'h69, '0, "R9");
    fa(0, 8'h25, '0, "R5");
    swr(5, 32'hC0C0_0025);
    fa(0, 8'h25, '0, "R4");

    // R4 window wrapping past the top of the address space
    @(negedge clk); ld_en = 1; ld_sp = 8'hF0;
    @(negedge clk); ld_en = 0;
    for (int i = 0; i < 256; i++) begin ev[i] = 0; dt[i] = 0; end
    sp_m = 8'hF0;
    swr(20, 32'h0A0B_0004);
    fa(0, 8'h04, '0, "R4");
    fa(0, 8'h10, '0, "R5");

    // R6 allocate across clean invalid words after load: no write-back
    mw0 = mw_cnt;
    do_cmd(1, 2, "R6");
    chk(mw_cnt == mw0, "R6", 32'(mw_cnt), 32'(mw0));
    sweep("R6");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule